// File: doc/BRIEF.md
# DDR Read Burst with Burst Stop

This block models, on the device side, the read data path of a double-data-rate synchronous DRAM. Decoded read and burst-stop commands are sampled on the rising clock edge. After a selectable CAS latency, the block drives a data word on every clock edge, rising and falling, together with a data strobe that toggles in step with the words. Every data word is built from a burst index and the column address. A controller-side testbench can therefore check both the order of the words and the point where a burst is cut short.

A burst-stop command truncates the burst that is in flight. The number of words that reach the pins is set by how many clocks separate the read from the stop. Output is released exactly one CAS latency after the stop. The latency can be a whole or a half clock; with a half clock, the first word launches on the falling edge. A registered-module setting adds one further clock to both the first word and the release. The strobe has a one-clock low preamble and a half-clock low postamble around each stretch of data.

Top module: `ddr_rd_burst`

## Requirements
- R1: An uninterrupted read drives 8 words on consecutive half-clock slots, two per clock. Word n (n = 0..7) equals the column address shifted left by 3 bits with n in the low 3 bits, zero-extended to the bus width.
- R2: With `cas_half` = 0 (latency 2.0) and `reg_mode` = 0, word 0 appears in the high phase of the second clock after the clock edge that sampled the read. With `cas_half` = 1 (latency 2.5), it appears one half clock later, in the low phase.
- R3: With `reg_mode` = 1, first data and output release both move one full clock later than the settings in R2 (latencies 3.0 and 3.5).
- R4: A stop sampled N clocks after its read (N = 1, 2 or 3) limits that burst to words 0..2N-1. `dq_oe` falls one CAS latency after the stop.
- R5: A stop sampled on the same edge as a read raises `proto_err` for exactly the following clock. The stop is discarded and the read proceeds as a full burst. `proto_err` is low at every other time.
- R6: A stop sampled while no burst is open is ignored. This includes a stop with no prior read and a stop 4 or more clocks after the read. The pins then show either nothing or the complete 8-word burst.
- R7: The strobe is driven low during the two half-clock slots just before the first word of a stretch of data.
- R8: While data is driven, the strobe is high with even-indexed words and low with odd-indexed words.
- R9: After the last word, the strobe stays driven low for one more half clock and is then released. `dq_oe` is high only during data slots, and whenever `dq_oe` is high, `dqs_oe` is high too.
- R10: A read sampled while an earlier burst is open ends that burst at the new read's clock. A read sampled after a stop starts from word 0 with its own latency. Consecutive bursts follow each other with no gap.
- R11: While `rst_n` is low, neither the data bus nor the strobe is driven and `proto_err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock; data changes on both of its edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | Decoded read command, sampled on the rising edge |
| term_cmd | input | 1 | Decoded burst-stop command, sampled on the rising edge |
| rd_col | input | COL_W | Column address accompanying a read |
| cas_half | input | 1 | 0 selects whole-clock latency, 1 adds half a clock |
| reg_mode | input | 1 | 1 adds the registered-module clock of latency |
| dq_out | output | DATA_W | Data bus value |
| dq_oe | output | 1 | Data bus drive enable |
| dqs_out | output | 1 | Data strobe value |
| dqs_oe | output | 1 | Data strobe drive enable |
| proto_err | output | 1 | One-clock flag for a stop on the same edge as a read |

## Verification
Full bursts are run under all four latency settings; only these show whether each half-clock and registered offset lands the first word in the right phase. Stops at one, two and three clocks tell apart the three truncation lengths. Stops at the read's own clock, with no read at all, and after the burst has ended must leave a full or empty burst, which isolates the rules for ignoring a stop. Chains of reads, including a read straight after a stop, a read interrupting an open burst and a read landing exactly at the end of the previous burst, show whether the strobe preamble gives way to live data and whether a new burst restarts at word 0.

// File: rtl/ddr_rd_pkg.sv
`timescale 1ns/1ps
package ddr_rd_pkg;

   typedef enum logic {
      CAS_WHOLE = 1'b0,
      CAS_HALF  = 1'b1
   } cas_frac_e;

   // Latency expressed in half-clock slots.
   function automatic int unsigned lat_halves(int unsigned base, cas_frac_e frac,
                                              logic regd, int unsigned extra);
      int unsigned h;
      h = 2 * base;
      if (frac == CAS_HALF) h = h + 1;
      if (regd) h = h + 2 * extra;
      return h;
   endfunction

endpackage

// File: rtl/ddr_rd_cmd.sv
`timescale 1ns/1ps
module ddr_rd_cmd #(
   parameter int COL_W = 10,
   parameter int PAIRS = 4,
   localparam int PW = $clog2(PAIRS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic             term,
   input  logic [COL_W-1:0] col_in,
   output logic             rec_vld,
   output logic [COL_W-1:0] rec_col,
   output logic [PW-1:0]    rec_pair,
   output logic             clash
);

   localparam logic [PW-1:0] LAST_PAIR = PW'(PAIRS - 1);

   logic             open_q;
   logic [PW-1:0]    pair_q;
   logic [COL_W-1:0] col_q;

   // Record for the current clock: one pair of words, or nothing.
   always_comb begin
      rec_vld  = rd | (open_q & ~term);
      rec_col  = rd ? col_in : col_q;
      rec_pair = rd ? '0 : pair_q;
      clash    = rd & term;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         pair_q <= '0;
         col_q  <= '0;
      end else if (rd) begin
         open_q <= 1'b1;
         pair_q <= PW'(1);
         col_q  <= col_in;
      end else if (open_q) begin
         if (term) begin
            open_q <= 1'b0;
         end else begin
            pair_q <= pair_q + PW'(1);
            open_q <= (pair_q != LAST_PAIR);
         end
      end
   end

endmodule

// File: rtl/ddr_rd_pipe.sv
`timescale 1ns/1ps
module ddr_rd_pipe #(
   parameter int DEPTH = 4,
   parameter int COL_W = 10,
   parameter int PW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [COL_W-1:0] in_col,
   input  logic [PW-1:0]    in_pair,
   output logic             vld_o  [DEPTH],
   output logic [COL_W-1:0] col_o  [DEPTH],
   output logic [PW-1:0]    pair_o [DEPTH]
);

   for (genvar j = 0; j < DEPTH; j++) begin : g_stage
      if (j == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_o[0]  <= 1'b0;
               col_o[0]  <= '0;
               pair_o[0] <= '0;
            end else begin
               vld_o[0]  <= in_vld;
               col_o[0]  <= in_col;
               pair_o[0] <= in_pair;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_o[j]  <= 1'b0;
               col_o[j]  <= '0;
               pair_o[j] <= '0;
            end else begin
               vld_o[j]  <= vld_o[j-1];
               col_o[j]  <= col_o[j-1];
               pair_o[j] <= pair_o[j-1];
            end
         end
      end
   end

endmodule

// File: rtl/ddr_rd_slot.sv
`timescale 1ns/1ps
module ddr_rd_slot #(
   parameter int HALVES = 8,
   parameter int DATA_W = 16,
   parameter int UW     = 3
) (
   input  logic              h_vld  [HALVES],
   input  logic [DATA_W-1:0] h_word [HALVES],
   input  logic              h_odd  [HALVES],
   input  logic [UW-1:0]     u,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq,
   output logic              dqs_oe,
   output logic              dqs
);

   logic              cur;
   logic              cur_odd;
   logic [DATA_W-1:0] cur_word;
   logic              ahead;
   logic              behind;

   // u counts half slots back from the newest one; smaller u lies later in time.
   always_comb begin
      int ui;
      ui       = int'(u);
      cur      = 1'b0;
      cur_odd  = 1'b0;
      cur_word = '0;
      ahead    = 1'b0;
      behind   = 1'b0;
      for (int i = 0; i < HALVES; i++) begin
         if (i == ui) begin
            cur      = h_vld[i];
            cur_odd  = h_odd[i];
            cur_word = h_word[i];
         end
         if ((i + 1 == ui) || (i + 2 == ui)) ahead  = ahead | h_vld[i];
         if (i == ui + 1)                    behind = behind | h_vld[i];
      end
      dq_oe  = cur;
      dq     = cur ? cur_word : '0;
      dqs_oe = cur | ahead | behind;
      dqs    = cur & ~cur_odd;
   end

endmodule

// File: rtl/ddr_rd_burst.sv
`timescale 1ns/1ps
module ddr_rd_burst #(
   parameter int DATA_W    = 16,
   parameter int COL_W     = 10,
   parameter int BURST_LEN = 8,
   parameter int CL_BASE   = 2,
   parameter int REG_EXTRA = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_cmd,
   input  logic              term_cmd,
   input  logic [COL_W-1:0]  rd_col,
   input  logic              cas_half,
   input  logic              reg_mode,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              dqs_out,
   output logic              dqs_oe,
   output logic              proto_err
);

   localparam int PAIRS  = BURST_LEN / 2;
   localparam int PW     = $clog2(PAIRS);
   localparam int IDX_W  = $clog2(BURST_LEN);
   localparam int LH_MAX = 2 * CL_BASE + 1 + 2 * REG_EXTRA;
   localparam int DEPTH  = LH_MAX / 2 + 1;
   localparam int HALVES = 2 * DEPTH;
   localparam int LW     = $clog2(LH_MAX + 1);

   if (BURST_LEN < 4 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_bl
      $error("BURST_LEN must be a power of two of at least 4");
   end
   if (CL_BASE < 2) begin : g_bad_cl
      $error("CL_BASE must be at least 2");
   end
   if (REG_EXTRA < 0) begin : g_bad_reg
      $error("REG_EXTRA must not be negative");
   end
   if (COL_W + IDX_W > DATA_W) begin : g_bad_w
      $error("DATA_W too narrow for column and burst index");
   end

   // Command stage
   logic             rec_vld;
   logic [COL_W-1:0] rec_col;
   logic [PW-1:0]    rec_pair;
   logic             clash;

   ddr_rd_cmd #(.COL_W(COL_W), .PAIRS(PAIRS)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (rd_cmd),
      .term     (term_cmd),
      .col_in   (rd_col),
      .rec_vld  (rec_vld),
      .rec_col  (rec_col),
      .rec_pair (rec_pair),
      .clash    (clash)
   );

   // Latency pipeline, one record per clock
   logic             p_vld  [DEPTH];
   logic [COL_W-1:0] p_col  [DEPTH];
   logic [PW-1:0]    p_pair [DEPTH];

   ddr_rd_pipe #(.DEPTH(DEPTH), .COL_W(COL_W), .PW(PW)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (rec_vld),
      .in_col  (rec_col),
      .in_pair (rec_pair),
      .vld_o   (p_vld),
      .col_o   (p_col),
      .pair_o  (p_pair)
   );

   // Unfold each record into its two half-clock words
   logic              h_vld  [HALVES];
   logic [DATA_W-1:0] h_word [HALVES];
   logic              h_odd  [HALVES];

   for (genvar j = 0; j < DEPTH; j++) begin : g_unfold
      for (genvar b = 0; b < 2; b++) begin : g_half
         // b = 0: later (odd) word, b = 1: earlier (even) word
         always_comb begin
            logic [DATA_W-1:0] w;
            w = '0;
            w[IDX_W-1:0]       = {p_pair[j], (b == 0) ? 1'b1 : 1'b0};
            w[IDX_W +: COL_W]  = p_col[j];
            h_vld[2*j+b]  = p_vld[j];
            h_word[2*j+b] = w;
            h_odd[2*j+b]  = (b == 0);
         end
      end
   end

   // Latency select
   ddr_rd_pkg::cas_frac_e frac;
   logic [LW-1:0]         lh;

   always_comb begin
      frac = ddr_rd_pkg::cas_frac_e'(cas_half);
      lh   = LW'(ddr_rd_pkg::lat_halves(CL_BASE, frac, reg_mode, REG_EXTRA));
   end

   // Slot decode for the high (h = 0) and low (h = 1) phase of the next clock
   logic              s_dq_oe  [2];
   logic [DATA_W-1:0] s_dq     [2];
   logic              s_dqs_oe [2];
   logic              s_dqs    [2];

   for (genvar h = 0; h < 2; h++) begin : g_phase
      logic [LW-1:0] u_sel;
      assign u_sel = lh - LW'(1 + h);
      ddr_rd_slot #(.HALVES(HALVES), .DATA_W(DATA_W), .UW(LW)) u_slot (
         .h_vld  (h_vld),
         .h_word (h_word),
         .h_odd  (h_odd),
         .u      (u_sel),
         .dq_oe  (s_dq_oe[h]),
         .dq     (s_dq[h]),
         .dqs_oe (s_dqs_oe[h]),
         .dqs    (s_dqs[h])
      );
   end

   // Registered phase values
   logic              hi_dq_oe, lo_dq_oe;
   logic [DATA_W-1:0] hi_dq, lo_dq;
   logic              hi_dqs_oe, lo_dqs_oe;
   logic              hi_dqs, lo_dqs;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_dq_oe  <= 1'b0;
         lo_dq_oe  <= 1'b0;
         hi_dq     <= '0;
         lo_dq     <= '0;
         hi_dqs_oe <= 1'b0;
         lo_dqs_oe <= 1'b0;
         hi_dqs    <= 1'b0;
         lo_dqs    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         hi_dq_oe  <= s_dq_oe[0];
         lo_dq_oe  <= s_dq_oe[1];
         hi_dq     <= s_dq[0];
         lo_dq     <= s_dq[1];
         hi_dqs_oe <= s_dqs_oe[0];
         lo_dqs_oe <= s_dqs_oe[1];
         hi_dqs    <= s_dqs[0];
         lo_dqs    <= s_dqs[1];
         err_q     <= clash;
      end
   end

   // Double-rate output select
   assign dq_out    = clk ? hi_dq     : lo_dq;
   assign dq_oe     = clk ? hi_dq_oe  : lo_dq_oe;
   assign dqs_out   = clk ? hi_dqs    : lo_dqs;
   assign dqs_oe    = clk ? hi_dqs_oe : lo_dqs_oe;
   assign proto_err = err_q;

endmodule

// File: rtl/ddr_rd_burst_chk.sv
`timescale 1ns/1ps
module ddr_rd_burst_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_cmd,
   input logic term_cmd,
   input logic proto_err,
   input logic hi_dq_oe,
   input logic lo_dq_oe,
   input logic hi_dqs_oe,
   input logic lo_dqs_oe,
   input logic hi_dqs,
   input logic lo_dqs
);

   // R5
   clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && term_cmd) |=> proto_err);

   // R5
   no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_cmd && term_cmd) |=> !proto_err);

   // R9
   hi_data_strobed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_dq_oe |-> hi_dqs_oe);

   // R9
   lo_data_strobed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_dq_oe |-> lo_dqs_oe);

   // R8
   strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_dq_oe && lo_dq_oe) |-> (hi_dqs != lo_dqs));

   // R7
   falling_launch_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_dq_oe && !hi_dq_oe) |-> (hi_dqs_oe && !hi_dqs));

endmodule

bind ddr_rd_burst ddr_rd_burst_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_cmd    (rd_cmd),
   .term_cmd  (term_cmd),
   .proto_err (proto_err),
   .hi_dq_oe  (hi_dq_oe),
   .lo_dq_oe  (lo_dq_oe),
   .hi_dqs_oe (hi_dqs_oe),
   .lo_dqs_oe (lo_dqs_oe),
   .hi_dqs    (hi_dqs),
   .lo_dqs    (lo_dqs)
);

// File: tb/tb_ddr_rd_burst.sv
`timescale 1ns/1ps
module tb_ddr_rd_burst;

   localparam int DATA_W = 16;
   localparam int COL_W  = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_cmd = 1'b0;
   logic              term_cmd = 1'b0;
   logic [COL_W-1:0]  rd_col = '0;
   logic              cas_half = 1'b0;
   logic              reg_mode = 1'b0;
   logic [DATA_W-1:0] dq_out;
   logic              dq_oe;
   logic              dqs_out;
   logic              dqs_oe;
   logic              proto_err;

   always #5 clk = ~clk;

   ddr_rd_burst dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_cmd    (rd_cmd),
      .term_cmd  (term_cmd),
      .rd_col    (rd_col),
      .cas_half  (cas_half),
      .reg_mode  (reg_mode),
      .dq_out    (dq_out),
      .dq_oe     (dq_oe),
      .dqs_out   (dqs_out),
      .dqs_oe    (dqs_oe),
      .proto_err (proto_err)
   );

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   // Reference timeline: expected word and index per absolute half slot
   int unsigned exp_w [int];
   int          exp_i [int];
   bit          m_open = 1'b0;
   int          m_c0 = 0;
   int          m_lh = 4;
   bit          e_err = 1'b0;

   int seen_words = 0;
   int first_slot = -1;
   int rd_first = -1;

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h (slot cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   function automatic int cur_lat();
      return 4 + int'(cas_half) + 2 * int'(reg_mode);
   endfunction

   function automatic void drop_from(int n_keep);
      for (int n = n_keep; n < 8; n++) begin
         int s;
         s = 2 * m_c0 + m_lh + n;
         if (exp_w.exists(s)) exp_w.delete(s);
         if (exp_i.exists(s)) exp_i.delete(s);
      end
   endfunction

   function automatic void model_step(bit rd, bit tm, logic [COL_W-1:0] col);
      e_err = rd && tm;
      if (rd) begin
         if (m_open && (cyc - m_c0) <= 3) drop_from(2 * (cyc - m_c0));
         m_open = 1'b1;
         m_c0   = cyc;
         m_lh   = cur_lat();
         for (int n = 0; n < 8; n++) begin
            exp_w[2 * cyc + m_lh + n] = (int'(col) << 3) | n;
            exp_i[2 * cyc + m_lh + n] = n;
         end
         if (rd_first < 0) rd_first = cyc;
      end else if (tm && m_open && (cyc - m_c0) <= 3) begin
         drop_from(2 * (cyc - m_c0));
         m_open = 1'b0;
      end
   endfunction

   task automatic check_slot(int s);
      bit d, ahead, strobe_exp;
      string t;
      d     = exp_w.exists(s);
      ahead = exp_w.exists(s + 1) || exp_w.exists(s + 2);
      strobe_exp = d || ahead || exp_w.exists(s - 1);
      if (dq_oe) begin
         seen_words++;
         if (first_slot < 0) first_slot = s;
      end
      t = !rst_n ? "R11" : (d ? "R1" : "R4");
      chk(dq_oe == d, t, "dq_oe", dq_oe, d);
      if (d && dq_oe) chk(dq_out == DATA_W'(exp_w[s]), "R1", "dq word", dq_out, exp_w[s]);
      t = !rst_n ? "R11" : ((!d && ahead) ? "R7" : "R9");
      chk(dqs_oe == strobe_exp, t, "dqs_oe", dqs_oe, strobe_exp);
      if (strobe_exp && dqs_oe) begin
         bit sv;
         sv = d && (exp_i[s] % 2 == 0);
         chk(dqs_out == sv, d ? "R8" : t, "dqs level", dqs_out, sv);
      end
   endtask

   // Monitor: reference update at each rising edge, checks in each phase
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         e_err = 1'b0;
         if (rst_n) model_step(rd_cmd, term_cmd, rd_col);
         #2.5;
         check_slot(2 * cyc);
         chk(proto_err == e_err, rst_n ? "R5" : "R11", "proto_err", proto_err, e_err);
         #5;
         check_slot(2 * cyc + 1);
      end
   end

   task automatic step(bit rd, bit tm, logic [COL_W-1:0] col);
      @(negedge clk);
      rd_cmd   = rd;
      term_cmd = tm;
      rd_col   = col;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0);
   endtask

   task automatic mark();
      seen_words = 0;
      first_slot = -1;
      rd_first   = -1;
   endtask

   task automatic scn_check(string tag, int words, int lh);
      chk(seen_words == words, tag, "word count", seen_words, words);
      if (words > 0)
         chk(first_slot - 2 * rd_first == lh, tag, "first data slot offset",
             first_slot - 2 * rd_first, lh);
   endtask

   // Read, then stop N clocks later (N = 0 means no stop)
   task automatic read_stop(logic [COL_W-1:0] col, int n);
      if (n == 0) begin
         step(1'b1, 1'b0, col);
      end else begin
         step(1'b1, 1'b0, col);
         for (int i = 1; i < n; i++) step(1'b0, 1'b0, '0);
         step(1'b0, 1'b1, '0);
      end
      idle(12);
   endtask

   task automatic set_cfg(bit ch, bit rm);
      @(negedge clk);
      cas_half = ch;
      reg_mode = rm;
      idle(2);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(3);

      // R1, R2: full burst, latency 2.0
      mark(); read_stop(10'h055, 0); scn_check("R1", 8, 4);
      // R4: stops after 1, 2 and 3 clocks
      mark(); read_stop(10'h1A3, 1); scn_check("R4", 2, 4);
      mark(); read_stop(10'h2B4, 2); scn_check("R4", 4, 4);
      mark(); read_stop(10'h3C5, 3); scn_check("R4", 6, 4);

      // R2: latency 2.5, full and truncated
      set_cfg(1'b1, 1'b0);
      mark(); read_stop(10'h0F0, 0); scn_check("R2", 8, 5);
      mark(); read_stop(10'h10F, 2); scn_check("R4", 4, 5);

      // R3: registered-module latencies 3.0 and 3.5
      set_cfg(1'b0, 1'b1);
      mark(); read_stop(10'h2AA, 3); scn_check("R3", 6, 6);
      mark(); read_stop(10'h155, 1); scn_check("R3", 2, 6);
      set_cfg(1'b1, 1'b1);
      mark(); read_stop(10'h3FF, 0); scn_check("R3", 8, 7);
      mark(); read_stop(10'h001, 2); scn_check("R3", 4, 7);
      set_cfg(1'b0, 1'b0);

      // R5: stop on the read's own edge
      mark(); step(1'b1, 1'b1, 10'h123); idle(12); scn_check("R5", 8, 4);

      // R6: stop with nothing open, stop after the burst ended
      mark(); step(1'b0, 1'b1, '0); idle(12); scn_check("R6", 0, 4);
      mark(); read_stop(10'h0AB, 4); scn_check("R6", 8, 4);
      mark(); read_stop(10'h0CD, 6); scn_check("R6", 8, 4);

      // R10: read right after a stop, read interrupting, back-to-back reads
      mark();
      step(1'b1, 1'b0, 10'h111); step(1'b0, 1'b1, '0); step(1'b1, 1'b0, 10'h222);
      idle(12); scn_check("R10", 10, 4);
      mark();
      step(1'b1, 1'b0, 10'h333); idle(1); step(1'b1, 1'b0, 10'h044);
      idle(12); scn_check("R10", 12, 4);
      set_cfg(1'b1, 1'b0);
      mark();
      step(1'b1, 1'b0, 10'h055); idle(3); step(1'b1, 1'b0, 10'h066);
      idle(12); scn_check("R10", 16, 5);
      set_cfg(1'b0, 1'b0);

      idle(4);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule